// File: doc/BRIEF.md
# Serial Port Modem-Line Flow Control Unit

This block sits between the transmit and receive datapath of a serial port configured as a DTE and the modem-control lines of that port. It holds a five-bit handshake mode word. From that word it drives the two outgoing request lines, RTS and DTR. It samples the two incoming status lines, CTS and CD. It tells the transmitter when it may start a character through a registered transmit-enable. The receive buffer logic raises a stop request when it needs the far end to pause. Depending on the mode, that request pulls the request lines low or stops the outgoing isochronous clock. The transmitter samples the transmit-enable only at character boundaries, so a character already on the line always finishes.

A mode word is written with a two-bit apply code. The change can take effect at once, wait until the transmit path has drained, or wait for the drain and then flush the receive queue before the new mode takes hold. A word that would use both request lines, or both status lines, for flow control at the same time is refused. The old mode stays in force and an error pulse is produced.

Top module: `hwfc_unit`

## Requirements
- R1: While `rst` is high, every output is low and the active mode word is cleared to zero.
- R2: While `port_open` is low, `rts_out`, `dtr_out` and `tx_enable` are low one cycle later. While it is high and no flow-control bit is set, all three are high one cycle later, whatever the values of `cts_in`, `cd_in` and `rx_stop_req`.
- R3: With mode bit 0 (request-line input control) set, `rts_out` goes low one cycle after `rx_stop_req` rises and returns high one cycle after it falls. `dtr_out` stays high.
- R4: With mode bit 2 (ready-line input control) set, `dtr_out` behaves the same way with `rx_stop_req`, and `rts_out` stays high.
- R5: With mode bit 1 (clear-line output control) set, `tx_enable` follows `cts_in`. Each change shows at `tx_enable` three clock edges after it appears at the input: two synchronizer flops plus the output register.
- R6: With mode bit 3 (carrier-line output control) set, `tx_enable` follows `cd_in` with the same three-edge latency.
- R7: `clk_gate_out` is low one cycle after mode bit 4, `clk_out_active` and `rx_stop_req` are all high, and is high otherwise. When `clk_out_active` is low, bit 4 has no effect.
- R8: A write whose mode word sets both bits 0 and 2, or both bits 1 and 3, is refused. `cfg_err` is high for exactly the one cycle after the write, and the active mode is unchanged.
- R9: Apply code 0 (and code 3) loads the mode at the write edge. The pins show the new mode one cycle after that.
- R10: Apply code 1 holds the word as pending. It loads at the first clock edge after the write edge at which `tx_drained` is high.
- R11: Apply code 2 waits the same way for `tx_drained`. At that edge `rx_flush` pulses high for one cycle, and the mode loads on the next edge.
- R12: A legal write replaces any pending word, including one that would otherwise load on the same edge. The replaced word never takes effect.
- R13: Bits 0 and 1 together give bidirectional control. `rts_out` follows `rx_stop_req` as in R3 while `tx_enable` follows `cts_in` as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_open | input | 1 | Port is open and enabled |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_mode | input | 5 | Mode word to write |
| cfg_apply | input | 2 | Apply code: 0/3 now, 1 after drain, 2 after drain plus receive flush |
| tx_drained | input | 1 | Transmit queue empty and no character in progress |
| rx_stop_req | input | 1 | Receive side asks the far end to stop sending |
| cts_in | input | 1 | Clear-to-send line from the far end, asynchronous |
| cd_in | input | 1 | Carrier-detect line from the far end, asynchronous |
| clk_out_active | input | 1 | Port is programmed to drive an outgoing clock |
| rts_out | output | 1 | Request-to-send line |
| dtr_out | output | 1 | Terminal-ready line |
| tx_enable | output | 1 | Transmitter may start a new character |
| clk_gate_out | output | 1 | Outgoing isochronous clock may run |
| rx_flush | output | 1 | One-cycle pulse to discard the receive queue |
| cfg_err | output | 1 | One-cycle pulse after a refused write |

## Verification
A deferred word that is about to load and a fresh write can land on the same clock edge. The bench provokes this by leaving a drain-deferred word pending with `tx_drained` low. On one negative edge it then raises `tx_drained` and presents an immediate write with a different word. The result is judged at the pins: the fresh word's behaviour must appear, and the pending word's request-line behaviour must never show in the cycles that follow. A refused write while a word is pending is judged the same way: the error pulse must appear, and the pending word must still load when the drain occurs.

// File: rtl/hwfc_pkg.sv
package hwfc_pkg;
  localparam int MODE_W  = 5;
  localparam int B_RTS   = 0;  // request line used for input control
  localparam int B_CTS   = 1;  // clear line gates output
  localparam int B_DTR   = 2;  // ready line used for input control
  localparam int B_CD    = 3;  // carrier line gates output
  localparam int B_ISO   = 4;  // outgoing clock stopped for input control

  typedef enum logic [1:0] {
    APPLY_NOW   = 2'd0,
    APPLY_DRAIN = 2'd1,
    APPLY_FLUSH = 2'd2,
    APPLY_NOW2  = 2'd3
  } apply_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FLUSH = 2'd2
  } cfg_state_t;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    return !(m[B_RTS] && m[B_DTR]) && !(m[B_CTS] && m[B_CD]);
  endfunction
endpackage

// File: rtl/hwfc_sync.sv
module hwfc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] r;
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) r <= '0;
          else     r <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) r <= '0;
          else     r <= g_stage[g-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/hwfc_cfg.sv
module hwfc_cfg
  import hwfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [1:0]        wr_apply,
  input  logic              tx_drained,
  output logic [MODE_W-1:0] mode_q,
  output logic [MODE_W-1:0] pend_q,
  output cfg_state_t        state_q,
  output logic              flush_q,
  output logic              err_q
);
  logic   legal;
  apply_t ap;
  logic   pend_flush;

  assign legal = mode_ok(wr_mode);
  assign ap    = apply_t'(wr_apply);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      pend_q     <= '0;
      pend_flush <= 1'b0;
      state_q    <= ST_IDLE;
      flush_q    <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      flush_q <= 1'b0;
      err_q   <= wr && !legal;
      if (wr && legal) begin
        case (ap)
          APPLY_DRAIN, APPLY_FLUSH: begin
            pend_q     <= wr_mode;
            pend_flush <= (ap == APPLY_FLUSH);
            state_q    <= ST_WAIT;
          end
          default: begin
            mode_q  <= wr_mode;
            state_q <= ST_IDLE;
          end
        endcase
      end else begin
        case (state_q)
          ST_WAIT: begin
            if (tx_drained) begin
              if (pend_flush) begin
                flush_q <= 1'b1;
                state_q <= ST_FLUSH;
              end else begin
                mode_q  <= pend_q;
                state_q <= ST_IDLE;
              end
            end
          end
          ST_FLUSH: begin
            mode_q  <= pend_q;
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hwfc_pins.sv
module hwfc_pins
  import hwfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              port_open,
  input  logic [MODE_W-1:0] mode,
  input  logic              rx_stop,
  input  logic              cts_s,
  input  logic              cd_s,
  input  logic              clk_out_active,
  output logic              rts_q,
  output logic              dtr_q,
  output logic              txen_q,
  output logic              gate_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rts_q  <= 1'b0;
      dtr_q  <= 1'b0;
      txen_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      rts_q  <= port_open && !(mode[B_RTS] && rx_stop);
      dtr_q  <= port_open && !(mode[B_DTR] && rx_stop);
      txen_q <= port_open && (!mode[B_CTS] || cts_s) && (!mode[B_CD] || cd_s);
      gate_q <= !(mode[B_ISO] && clk_out_active && rx_stop);
    end
  end
endmodule

// File: rtl/hwfc_unit.sv
module hwfc_unit
  import hwfc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       port_open,
  input  logic       cfg_wr,
  input  logic [4:0] cfg_mode,
  input  logic [1:0] cfg_apply,
  input  logic       tx_drained,
  input  logic       rx_stop_req,
  input  logic       cts_in,
  input  logic       cd_in,
  input  logic       clk_out_active,
  output logic       rts_out,
  output logic       dtr_out,
  output logic       tx_enable,
  output logic       clk_gate_out,
  output logic       rx_flush,
  output logic       cfg_err
);
  localparam int LINES = 2;

  logic [LINES-1:0]  line_s;
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] pend_q;
  cfg_state_t        state_q;

  hwfc_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cd_in, cts_in}),
    .q   (line_s)
  );

  hwfc_cfg u_cfg (
    .clk        (clk),
    .rst        (rst),
    .wr         (cfg_wr),
    .wr_mode    (cfg_mode),
    .wr_apply   (cfg_apply),
    .tx_drained (tx_drained),
    .mode_q     (mode_q),
    .pend_q     (pend_q),
    .state_q    (state_q),
    .flush_q    (rx_flush),
    .err_q      (cfg_err)
  );

  hwfc_pins u_pins (
    .clk            (clk),
    .rst            (rst),
    .port_open      (port_open),
    .mode           (mode_q),
    .rx_stop        (rx_stop_req),
    .cts_s          (line_s[0]),
    .cd_s           (line_s[1]),
    .clk_out_active (clk_out_active),
    .rts_q          (rts_out),
    .dtr_q          (dtr_out),
    .txen_q         (tx_enable),
    .gate_q         (clk_gate_out)
  );
endmodule

// File: rtl/hwfc_unit_chk.sv
module hwfc_unit_chk
  import hwfc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              port_open,
  input logic              rx_stop_req,
  input logic              cfg_wr,
  input logic [MODE_W-1:0] cfg_mode,
  input logic              rts_out,
  input logic              dtr_out,
  input logic              tx_enable,
  input logic              rx_flush,
  input logic              cfg_err,
  input logic [MODE_W-1:0] mode_q,
  input logic [MODE_W-1:0] pend_q,
  input logic [1:0]        state_q
);
  logic bad_wr;
  assign bad_wr = cfg_wr && !mode_ok(cfg_mode);

  AST_CLOSED_LOW: assert property (@(posedge clk) disable iff (rst)
    !port_open |=> (!rts_out && !dtr_out && !tx_enable)); // R2

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (port_open && !rx_stop_req) |=> (rts_out && dtr_out)); // R2

  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> cfg_err); // R8

  AST_REJECT_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    (bad_wr && state_q == 2'd0) |=> $stable(mode_q)); // R8

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> $past(cfg_wr)); // R8

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_ok(mode_q)); // R8

  AST_FLUSH_THEN_LOAD: assert property (@(posedge clk) disable iff (rst)
    (rx_flush && !cfg_wr) |=> (mode_q == $past(pend_q))); // R11

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> !rx_flush); // R11
endmodule

bind hwfc_unit hwfc_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .port_open   (port_open),
  .rx_stop_req (rx_stop_req),
  .cfg_wr      (cfg_wr),
  .cfg_mode    (cfg_mode),
  .rts_out     (rts_out),
  .dtr_out     (dtr_out),
  .tx_enable   (tx_enable),
  .rx_flush    (rx_flush),
  .cfg_err     (cfg_err),
  .mode_q      (mode_q),
  .pend_q      (pend_q),
  .state_q     (state_q)
);

// File: tb/hwfc_unit_bench.sv
module hwfc_unit_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst, port_open, cfg_wr, tx_drained, rx_stop_req;
  logic       cts_in, cd_in, clk_out_active;
  logic [4:0] cfg_mode;
  logic [1:0] cfg_apply;
  logic       rts_out, dtr_out, tx_enable, clk_gate_out, rx_flush, cfg_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  hwfc_unit u_hwfc_unit (
    .clk(clk), .rst(rst), .port_open(port_open), .cfg_wr(cfg_wr),
    .cfg_mode(cfg_mode), .cfg_apply(cfg_apply), .tx_drained(tx_drained),
    .rx_stop_req(rx_stop_req), .cts_in(cts_in), .cd_in(cd_in),
    .clk_out_active(clk_out_active), .rts_out(rts_out), .dtr_out(dtr_out),
    .tx_enable(tx_enable), .clk_gate_out(clk_gate_out), .rx_flush(rx_flush),
    .cfg_err(cfg_err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input logic [4:0] m, input logic [1:0] a);
    cfg_mode  = m;
    cfg_apply = a;
    cfg_wr    = 1'b1;
    @(negedge clk);
    cfg_wr    = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rts in reset", rts_out, 1'b0);
    check("R1 dtr in reset", dtr_out, 1'b0);
    check("R1 tx_enable in reset", tx_enable, 1'b0);
    check("R1 clk_gate in reset", clk_gate_out, 1'b0);
    check("R1 rx_flush in reset", rx_flush, 1'b0);
    check("R1 cfg_err in reset", cfg_err, 1'b0);
  endtask

  task automatic t_open_plain;
    tick(1);
    check("R2 closed rts", rts_out, 1'b0);
    check("R2 closed tx_enable", tx_enable, 1'b0);
    port_open = 1'b1; rx_stop_req = 1'b1; cts_in = 1'b0; cd_in = 1'b0;
    tick(1);
    check("R2 open rts", rts_out, 1'b1);
    check("R2 open dtr", dtr_out, 1'b1);
    tick(3);
    check("R2 open tx_enable ignores lines", tx_enable, 1'b1);
    cts_in = 1'b1; cd_in = 1'b1; rx_stop_req = 1'b0;
    tick(3);
  endtask

  task automatic t_rts;
    rx_stop_req = 1'b1;
    tick(1);
    cfg_write(5'b00001, 2'd0);
    check("R9 old mode still on pins", rts_out, 1'b1);
    tick(1);
    check("R9 R3 rts low under stop", rts_out, 1'b0);
    check("R3 dtr stays high", dtr_out, 1'b1);
    rx_stop_req = 1'b0;
    tick(1);
    check("R3 rts back high", rts_out, 1'b1);
  endtask

  task automatic t_dtr;
    cfg_write(5'b00100, 2'd3);
    tick(1);
    rx_stop_req = 1'b1;
    tick(1);
    check("R4 dtr low under stop", dtr_out, 1'b0);
    check("R4 rts stays high", rts_out, 1'b1);
    rx_stop_req = 1'b0;
    tick(1);
    check("R4 dtr back high", dtr_out, 1'b1);
  endtask

  task automatic t_cts;
    cfg_write(5'b00010, 2'd0);
    tick(1);
    cts_in = 1'b0;
    tick(2);
    check("R5 tx_enable before sync delay", tx_enable, 1'b1);
    tick(1);
    check("R5 tx_enable low after cts falls", tx_enable, 1'b0);
    cts_in = 1'b1;
    tick(2);
    check("R5 tx_enable still low", tx_enable, 1'b0);
    tick(1);
    check("R5 tx_enable resumes", tx_enable, 1'b1);
  endtask

  task automatic t_cd;
    cfg_write(5'b01000, 2'd0);
    tick(1);
    cts_in = 1'b0;
    tick(4);
    check("R6 cts ignored in carrier mode", tx_enable, 1'b1);
    cts_in = 1'b1; cd_in = 1'b0;
    tick(3);
    check("R6 tx_enable low after cd falls", tx_enable, 1'b0);
    cd_in = 1'b1;
    tick(3);
    check("R6 tx_enable resumes", tx_enable, 1'b1);
  endtask

  task automatic t_iso;
    cfg_write(5'b10000, 2'd0);
    clk_out_active = 1'b1; rx_stop_req = 1'b1;
    tick(1);
    check("R7 clock gated", clk_gate_out, 1'b0);
    check("R7 rts unaffected", rts_out, 1'b1);
    clk_out_active = 1'b0;
    tick(1);
    check("R7 bit ignored without clock output", clk_gate_out, 1'b1);
    clk_out_active = 1'b1; rx_stop_req = 1'b0;
    tick(1);
    check("R7 clock runs without stop", clk_gate_out, 1'b1);
  endtask

  task automatic t_illegal;
    cfg_write(5'b00001, 2'd0);
    tick(1);
    cfg_write(5'b00101, 2'd0);
    check("R8 error pulse", cfg_err, 1'b1);
    tick(1);
    check("R8 error single cycle", cfg_err, 1'b0);
    cfg_write(5'b01010, 2'd1);
    check("R8 error pulse output pair", cfg_err, 1'b1);
    rx_stop_req = 1'b1;
    tick(2);
    check("R8 old mode kept rts", rts_out, 1'b0);
    check("R8 old mode kept dtr", dtr_out, 1'b1);
    rx_stop_req = 1'b0;
    tick(1);
  endtask

  task automatic t_defer;
    tx_drained = 1'b0;
    rx_stop_req = 1'b1;
    cfg_write(5'b00100, 2'd1);
    cfg_write(5'b00101, 2'd0);
    check("R8 refused while pending", cfg_err, 1'b1);
    tick(4);
    check("R10 held while draining rts", rts_out, 1'b0);
    check("R10 held while draining dtr", dtr_out, 1'b1);
    tx_drained = 1'b1;
    tick(1);
    check("R10 pins one cycle behind load", dtr_out, 1'b1);
    tick(1);
    check("R10 new mode dtr", dtr_out, 1'b0);
    check("R10 new mode rts", rts_out, 1'b1);
    rx_stop_req = 1'b0;
    tick(1);
  endtask

  task automatic t_flush;
    rx_stop_req = 1'b1;
    tick(1);
    cfg_write(5'b00001, 2'd2);
    check("R11 no flush at write", rx_flush, 1'b0);
    tick(1);
    check("R11 flush pulse", rx_flush, 1'b1);
    check("R11 mode not yet loaded", dtr_out, 1'b0);
    tick(1);
    check("R11 flush single", rx_flush, 1'b0);
    check("R11 old mode during flush edge", rts_out, 1'b1);
    tick(1);
    check("R11 new mode rts", rts_out, 1'b0);
    check("R11 new mode dtr", dtr_out, 1'b1);
    rx_stop_req = 1'b0;
    tick(1);
  endtask

  task automatic t_collide;
    tx_drained = 1'b0;
    cfg_write(5'b00100, 2'd1);
    rx_stop_req = 1'b1;
    tx_drained = 1'b1;
    cfg_write(5'b00010, 2'd0);
    tick(1);
    check("R12 fresh word rts", rts_out, 1'b1);
    check("R12 pending word dropped", dtr_out, 1'b1);
    cts_in = 1'b0;
    tick(3);
    check("R12 fresh word gates output", tx_enable, 1'b0);
    tick(3);
    check("R12 pending word never loads", dtr_out, 1'b1);
    cts_in = 1'b1; rx_stop_req = 1'b0;
    tick(3);
  endtask

  task automatic t_bidir;
    cfg_write(5'b00011, 2'd0);
    tick(1);
    rx_stop_req = 1'b1; cts_in = 1'b0;
    tick(1);
    check("R13 rts low", rts_out, 1'b0);
    tick(2);
    check("R13 tx_enable low", tx_enable, 1'b0);
    rx_stop_req = 1'b0;
    tick(1);
    check("R13 rts high with cts still low", rts_out, 1'b1);
    check("R13 tx_enable stays low", tx_enable, 1'b0);
    cts_in = 1'b1;
    tick(3);
    check("R13 tx_enable back", tx_enable, 1'b1);
  endtask

  task automatic t_close;
    port_open = 1'b0;
    tick(1);
    check("R2 close rts", rts_out, 1'b0);
    check("R2 close dtr", dtr_out, 1'b0);
    check("R2 close tx_enable", tx_enable, 1'b0);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; port_open = 1'b0; cfg_wr = 1'b0; cfg_mode = '0; cfg_apply = '0;
    tx_drained = 1'b1; rx_stop_req = 1'b0; cts_in = 1'b1; cd_in = 1'b1;
    clk_out_active = 1'b0;
    tick(3);
    t_reset();
    rst = 1'b0;
    t_open_plain();
    t_rts();
    t_dtr();
    t_cts();
    t_cd();
    t_iso();
    t_illegal();
    t_defer();
    t_flush();
    t_collide();
    t_bidir();
    t_close();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule